// File: doc/BRIEF.md
# CAM Register-Access Command Decoder

This block handles the non-search control cycles of a content-addressable lookup coprocessor. On every clock it samples one command: a 12-bit op-code, an active-low write strobe, a command-valid strobe, a half-select line and a 32-bit data word. It then executes a no-op, a next-free-location read, a read or a write of the address, configuration or device-select register, a status read, or one half of a 64-bit comparand write. Every register write can be filtered bit by bit through one of seven loadable mask registers. A slot-validity array with a lowest-index-first priority scan supplies the next-free location.

The external bidirectional data bus is presented as three pins: an input word, an output word and an output enable. Read data leaves one clock after the command. Commands arrive at a fixed rate of one per clock. There is no valid/ready pair and no back-pressure, because the block always consumes a command in the cycle it is presented. Mask loading and validity-bit updates use plain side ports.

Top module: `cam_regacc`

## Requirements
- R1: A write with `cmd_wr_n`=0 and mask field 000 replaces the whole address (function code 000100), configuration (000110) or device-select (001000) register with `dq_in`. A later read of that register with `cmd_wr_n`=1 returns the stored word.
- R2: Op-code bits 8:6 name a mask register. When that field is non-zero, a register write updates only the bit positions where the selected mask holds 0. Every bit where the mask holds 1 keeps its old value. Writes to 32-bit registers use mask bits 31:0.
- R3: Mask registers 1 to 7 are loaded through the `mask_ld_*` port. A mask field of 000 always means an unmasked write, even after a load aimed at index 0.
- R4: A comparand write (function code 000101, `cmd_wr_n`=0) loads `cmp_key[31:0]` when `cmd_half`=0 and `cmp_key[63:32]` when `cmd_half`=1. Each half is masked by the same half of the selected mask.
- R5: A next-free read (function code 000011, `cmd_wr_n`=1) with at least one validity bit set returns the lowest set index on bits 11:0 and `page_id` on bits 19:16. It drives bits 15:12 and 31:20 to 0.
- R6: With no validity bit set, `full`=1 and a next-free read returns an all-zero word.
- R7: Function code 000011 with `cmd_wr_n`=0 is a no-op. It leaves every register unchanged and produces no read.
- R8: `dq_oe` is 1 only in the cycle after an accepted read. In that cycle `dq_out` holds the read value. At all other times `dq_oe` and `dq_out` are 0. Op-code bits 11:9 and the mask field do not affect reads.
- R9: The block treats the following as illegal: an unknown function code, a write to status (000111), a read of the comparand, or `cmd_half`=1 on anything but a comparand write. An illegal command changes no register and produces no read. It also sets a sticky flag, which appears on status bit 0. Status bit 1 mirrors `full`, and the other status bits are 0.
- R10: A cycle with `cmd_addr_valid`=0 is ignored. It changes no state, produces no read and does not set the illegal flag.
- R11: After reset, all registers, the comparand and the illegal flag are 0, every validity bit is clear (`full`=1), and `dq_oe`=0.
- R12: A mask load or validity update takes effect from the next cycle. A command in the same cycle uses the earlier mask or validity state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 12 | Op-code: bits 5:0 function, bits 8:6 mask select |
| cmd_wr_n | input | 1 | 0 = write from bus, 1 = read to bus |
| cmd_addr_valid | input | 1 | Command strobe; must be 1 for a control cycle |
| cmd_half | input | 1 | Comparand half select; 0 otherwise |
| dq_in | input | 32 | Write data from the bus |
| dq_out | output | 32 | Read data to the bus |
| dq_oe | output | 1 | Bus output enable |
| page_id | input | 4 | Device page address reported by next-free reads |
| mask_ld_en | input | 1 | Mask register load strobe |
| mask_ld_sel | input | 3 | Mask register index to load |
| mask_ld_data | input | 64 | Mask value to load |
| vld_wr_en | input | 1 | Validity bit update strobe |
| vld_idx | input | 6 | Validity bit index |
| vld_set | input | 1 | Value written to the validity bit |
| cmp_key | output | 64 | Comparand register contents |
| full | output | 1 | No validity bit is set |

## Verification
Two pairs of functions can share a cycle. A side-port mask load can land in the same cycle as a masked write that names that mask, and a validity update can land in the same cycle as a next-free read. The bench drives both pairs together on one clock edge. It expects the write to be filtered by the old mask and the read to report the old lowest index. The command that follows must then show the new mask and the new index.

// File: rtl/cam_regacc_pkg.sv
package cam_regacc_pkg;

  localparam int OP_W = 12;

  localparam logic [5:0] FN_NOP_NFA = 6'b000011;
  localparam logic [5:0] FN_ADR     = 6'b000100;
  localparam logic [5:0] FN_CMP     = 6'b000101;
  localparam logic [5:0] FN_CFG     = 6'b000110;
  localparam logic [5:0] FN_STS     = 6'b000111;
  localparam logic [5:0] FN_DEV     = 6'b001000;

  typedef enum logic [3:0] {
    OP_IDLE, OP_NOP, OP_NFA_RD,
    OP_ADR_WR, OP_ADR_RD, OP_CFG_WR, OP_CFG_RD,
    OP_DEV_WR, OP_DEV_RD, OP_STS_RD, OP_CMP_WR, OP_BAD
  } cmd_e;

  typedef struct packed {
    cmd_e       cmd;
    logic [2:0] msel;
    logic       is_read;
    logic       bad;
  } dec_t;

endpackage

// File: rtl/cam_cmd_decode.sv
module cam_cmd_decode
  import cam_regacc_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            wr_n,
  input  logic            addr_valid,
  input  logic            half,
  output dec_t            dec
);

  always_comb begin
    dec      = '0;
    dec.cmd  = OP_IDLE;
    dec.msel = op[8:6];
    if (addr_valid) begin
      case (op[5:0])
        FN_NOP_NFA: dec.cmd = wr_n ? OP_NFA_RD : OP_NOP;
        FN_ADR:     dec.cmd = wr_n ? OP_ADR_RD : OP_ADR_WR;
        FN_CFG:     dec.cmd = wr_n ? OP_CFG_RD : OP_CFG_WR;
        FN_DEV:     dec.cmd = wr_n ? OP_DEV_RD : OP_DEV_WR;
        FN_STS:     dec.cmd = wr_n ? OP_STS_RD : OP_BAD;
        FN_CMP:     dec.cmd = wr_n ? OP_BAD    : OP_CMP_WR;
        default:    dec.cmd = OP_BAD;
      endcase
      if (half && dec.cmd != OP_CMP_WR) dec.cmd = OP_BAD;
    end
    dec.is_read = (dec.cmd == OP_NFA_RD) || (dec.cmd == OP_ADR_RD) ||
                  (dec.cmd == OP_CFG_RD) || (dec.cmd == OP_DEV_RD) ||
                  (dec.cmd == OP_STS_RD);
    dec.bad     = (dec.cmd == OP_BAD);
  end

endmodule

// File: rtl/cam_mask_bank.sv
module cam_mask_bank #(
  parameter  int NMASK = 8,
  parameter  int MW    = 64,
  localparam int SW    = $clog2(NMASK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic [MW-1:0] ld_data,
  input  logic [SW-1:0] sel,
  output logic [MW-1:0] mask
);

  // Index 0 is the fixed all-zero mask; only indices 1..NMASK-1 hold storage.
  logic [MW-1:0] mreg [1:NMASK-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 1; k < NMASK; k++) mreg[k] <= '0;
    end else begin
      for (int k = 1; k < NMASK; k++)
        if (ld_en && ld_sel == SW'(k)) mreg[k] <= ld_data;
    end
  end

  always_comb begin
    mask = '0;
    for (int k = 1; k < NMASK; k++)
      if (sel == SW'(k)) mask = mreg[k];
  end

  // R12: a load is visible from the following cycle
  load_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel != '0 && sel == ld_sel) |=> (mask == $past(ld_data)) || (sel != $past(sel)));

endmodule

// File: rtl/cam_free_scan.sv
module cam_free_scan #(
  parameter  int DEPTH = 64,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic          upd_val,
  output logic [IW-1:0] first_idx,
  output logic          none_set
);

  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      vld_q <= '0;
    else if (upd_en) vld_q[upd_idx] <= upd_val;
  end

  // Lowest index wins: scan downward so the last hit is the smallest one.
  always_comb begin
    first_idx = '0;
    none_set  = 1'b1;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i]) begin
        first_idx = IW'(i);
        none_set  = 1'b0;
      end
    end
  end

  // R5
  first_is_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !none_set |-> vld_q[first_idx]);

  // R12: an update lands on the next edge
  upd_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (vld_q[$past(upd_idx)] == $past(upd_val)));

endmodule

// File: rtl/cam_regacc.sv
module cam_regacc
  import cam_regacc_pkg::*;
#(
  parameter  int DW       = 32,
  parameter  int NMASK    = 8,
  parameter  int DEPTH    = 64,
  parameter  int PAGE_W   = 4,
  parameter  int NFA_W    = 12,
  parameter  int PAGE_LSB = 16,
  localparam int CW       = 2 * DW,
  localparam int SW       = $clog2(NMASK),
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic              cmd_wr_n,
  input  logic              cmd_addr_valid,
  input  logic              cmd_half,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  input  logic [PAGE_W-1:0] page_id,
  input  logic              mask_ld_en,
  input  logic [SW-1:0]     mask_ld_sel,
  input  logic [CW-1:0]     mask_ld_data,
  input  logic              vld_wr_en,
  input  logic [IDX_W-1:0]  vld_idx,
  input  logic              vld_set,
  output logic [CW-1:0]     cmp_key,
  output logic              full
);

  dec_t             dec;
  logic [CW-1:0]    mask;
  logic [DW-1:0]    mlo, mhi;
  logic [IDX_W-1:0] free_idx;
  logic             none_set;
  logic [DW-1:0]    adr_q, cfg_q, dev_q;
  logic [CW-1:0]    cmp_q;
  logic             illegal_q;
  logic [DW-1:0]    nfa_word, sts_word, rd_word;

  cam_cmd_decode u_dec (
    .op(cmd_op), .wr_n(cmd_wr_n), .addr_valid(cmd_addr_valid),
    .half(cmd_half), .dec(dec)
  );

  cam_mask_bank #(.NMASK(NMASK), .MW(CW)) u_mask (
    .clk(clk), .rst_n(rst_n), .ld_en(mask_ld_en), .ld_sel(mask_ld_sel),
    .ld_data(mask_ld_data), .sel(dec.msel[SW-1:0]), .mask(mask)
  );

  cam_free_scan #(.DEPTH(DEPTH)) u_scan (
    .clk(clk), .rst_n(rst_n), .upd_en(vld_wr_en), .upd_idx(vld_idx),
    .upd_val(vld_set), .first_idx(free_idx), .none_set(none_set)
  );

  assign mlo = mask[DW-1:0];
  assign mhi = mask[CW-1:DW];

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v,
                                          input logic [DW-1:0] new_v,
                                          input logic [DW-1:0] keep);
    return (old_v & keep) | (new_v & ~keep);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_q     <= '0;
      cfg_q     <= '0;
      dev_q     <= '0;
      cmp_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      case (dec.cmd)
        OP_ADR_WR: adr_q <= merge(adr_q, dq_in, mlo);
        OP_CFG_WR: cfg_q <= merge(cfg_q, dq_in, mlo);
        OP_DEV_WR: dev_q <= merge(dev_q, dq_in, mlo);
        OP_CMP_WR: begin
          if (cmd_half) cmp_q[CW-1:DW] <= merge(cmp_q[CW-1:DW], dq_in, mhi);
          else          cmp_q[DW-1:0]  <= merge(cmp_q[DW-1:0],  dq_in, mlo);
        end
        OP_BAD:    illegal_q <= 1'b1;
        default:   ;
      endcase
    end
  end

  always_comb begin
    nfa_word = '0;
    if (!none_set) begin
      nfa_word[NFA_W-1:0]            = NFA_W'(free_idx);
      nfa_word[PAGE_LSB +: PAGE_W]   = page_id;
    end
    sts_word    = '0;
    sts_word[0] = illegal_q;
    sts_word[1] = none_set;
    case (dec.cmd)
      OP_NFA_RD: rd_word = nfa_word;
      OP_ADR_RD: rd_word = adr_q;
      OP_CFG_RD: rd_word = cfg_q;
      OP_DEV_RD: rd_word = dev_q;
      OP_STS_RD: rd_word = sts_word;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe  <= dec.is_read;
      dq_out <= dec.is_read ? rd_word : '0;
    end
  end

  assign cmp_key = cmp_q;
  assign full    = none_set;

  // R8
  oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(dec.is_read));

  // R10
  idle_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_addr_valid |=> !dq_oe);

  // R9
  sticky_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |=> illegal_q);

  // R7
  nop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.cmd == OP_NOP) |=> ($stable(adr_q) && $stable(cfg_q) && $stable(dev_q)
                             && $stable(cmp_q) && $stable(illegal_q)));

  // R2
  masked_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.cmd == OP_ADR_WR) |=> ((adr_q & $past(mlo)) == ($past(adr_q) & $past(mlo))));

endmodule

// File: tb/tb_cam_regacc.sv
module tb_cam_regacc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cmd_op = '0;
  logic        cmd_wr_n = 1'b0;
  logic        cmd_addr_valid = 1'b0;
  logic        cmd_half = 1'b0;
  logic [31:0] dq_in = '0;
  logic [31:0] dq_out;
  logic        dq_oe;
  logic [3:0]  page_id = 4'hA;
  logic        mask_ld_en = 1'b0;
  logic [2:0]  mask_ld_sel = '0;
  logic [63:0] mask_ld_data = '0;
  logic        vld_wr_en = 1'b0;
  logic [5:0]  vld_idx = '0;
  logic        vld_set = 1'b0;
  logic [63:0] cmp_key;
  logic        full;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  cam_regacc dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_wr_n(cmd_wr_n),
    .cmd_addr_valid(cmd_addr_valid), .cmd_half(cmd_half), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .page_id(page_id),
    .mask_ld_en(mask_ld_en), .mask_ld_sel(mask_ld_sel), .mask_ld_data(mask_ld_data),
    .vld_wr_en(vld_wr_en), .vld_idx(vld_idx), .vld_set(vld_set),
    .cmp_key(cmp_key), .full(full)
  );

  typedef struct packed {
    logic [11:0] op;
    logic        wr_n;
    logic        av;
    logic        hs;
    logic [31:0] din;
    logic        exp_oe;
    logic [31:0] exp_dq;
    logic [63:0] exp_cmp;
  } vec_t;

  localparam logic [63:0] C1 = 64'h00000000_11112222;
  localparam logic [63:0] C2 = 64'h33004400_11112222;
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{12'h004, 1'b0, 1'b1, 1'b0, 32'h12345678, 1'b0, 32'h0,        64'h0}, // R1
    '{12'h004, 1'b1, 1'b1, 1'b0, 32'h0,        1'b1, 32'h12345678, 64'h0}, // R1
    '{12'h006, 1'b0, 1'b1, 1'b0, 32'hCAFEF00D, 1'b0, 32'h0,        64'h0}, // R1
    '{12'h006, 1'b1, 1'b1, 1'b0, 32'h0,        1'b1, 32'hCAFEF00D, 64'h0}, // R1
    '{12'h008, 1'b0, 1'b1, 1'b0, 32'h000000A5, 1'b0, 32'h0,        64'h0}, // R1
    '{12'h008, 1'b1, 1'b1, 1'b0, 32'h0,        1'b1, 32'h000000A5, 64'h0}, // R1
    '{12'h044, 1'b0, 1'b1, 1'b0, 32'hAAAABBBB, 1'b0, 32'h0,        64'h0}, // R2
    '{12'h004, 1'b1, 1'b1, 1'b0, 32'h0,        1'b1, 32'h1234BBBB, 64'h0}, // R2
    '{12'h005, 1'b0, 1'b1, 1'b0, 32'h11112222, 1'b0, 32'h0,        C1},    // R4
    '{12'h045, 1'b0, 1'b1, 1'b1, 32'h33334444, 1'b0, 32'h0,        C2},    // R4
    '{12'h003, 1'b1, 1'b1, 1'b0, 32'h0,        1'b1, 32'h000A0005, C2},    // R5
    '{12'h003, 1'b0, 1'b1, 1'b0, 32'hFFFFFFFF, 1'b0, 32'h0,        C2},    // R7
    '{12'h004, 1'b1, 1'b1, 1'b0, 32'h0,        1'b1, 32'h1234BBBB, C2},    // R7
    '{12'h00F, 1'b0, 1'b1, 1'b0, 32'hDEADBEEF, 1'b0, 32'h0,        C2},    // R9
    '{12'h007, 1'b1, 1'b1, 1'b0, 32'h0,        1'b1, 32'h00000001, C2},    // R9
    '{12'h004, 1'b0, 1'b1, 1'b1, 32'h0,        1'b0, 32'h0,        C2},    // R9
    '{12'h004, 1'b1, 1'b1, 1'b0, 32'h0,        1'b1, 32'h1234BBBB, C2},    // R9
    '{12'h006, 1'b0, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0,        C2},    // R10
    '{12'h006, 1'b1, 1'b1, 1'b0, 32'h0,        1'b1, 32'hCAFEF00D, C2},    // R10
    '{12'h007, 1'b1, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0,        C2},    // R8
    '{12'h005, 1'b1, 1'b1, 1'b0, 32'h0,        1'b0, 32'h0,        C2},    // R9
    '{12'h1C4, 1'b1, 1'b1, 1'b0, 32'h0,        1'b1, 32'h1234BBBB, C2}     // R8
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one command at a falling edge; return at the next falling edge,
  // when the registered outputs of that command are visible.
  task automatic issue(input logic [11:0] op, input logic wr_n, input logic av,
                       input logic hs, input logic [31:0] din);
    cmd_op = op; cmd_wr_n = wr_n; cmd_addr_valid = av; cmd_half = hs; dq_in = din;
    @(negedge clk);
    cmd_addr_valid = 1'b0; cmd_half = 1'b0; cmd_wr_n = 1'b0;
    mask_ld_en = 1'b0; vld_wr_en = 1'b0;
  endtask

  task automatic set_vld(input int idx, input logic val);
    vld_wr_en = 1'b1; vld_idx = 6'(idx); vld_set = val;
    @(negedge clk);
    vld_wr_en = 1'b0;
  endtask

  task automatic load_mask(input int sel, input logic [63:0] m);
    mask_ld_en = 1'b1; mask_ld_sel = 3'(sel); mask_ld_data = m;
    @(negedge clk);
    mask_ld_en = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 oe", {63'b0, dq_oe}, 64'd0);
    chk("R11 dq", {32'b0, dq_out}, 64'd0);
    chk("R11 cmp", cmp_key, 64'd0);
    chk("R11 full", {63'b0, full}, 64'd1);
    issue(12'h004, 1'b1, 1'b1, 1'b0, 32'h0);
    chk("R11 adr", {31'b0, dq_oe, dq_out}, {31'b0, 1'b1, 32'h0});

    load_mask(1, 64'h00FF00FF_FFFF0000);
    set_vld(9, 1'b1);
    set_vld(5, 1'b1);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].wr_n, VEC[i].av, VEC[i].hs, VEC[i].din);
      chk($sformatf("vec%0d oe", i), {63'b0, dq_oe}, {63'b0, VEC[i].exp_oe});
      chk($sformatf("vec%0d dq", i), {32'b0, dq_out}, {32'b0, VEC[i].exp_dq});
      chk($sformatf("vec%0d cmp", i), cmp_key, VEC[i].exp_cmp);
    end

    // R3: a load at index 0 leaves mask field 000 unmasked
    load_mask(0, 64'hFFFFFFFF_FFFFFFFF);
    issue(12'h008, 1'b0, 1'b1, 1'b0, 32'h5A5A5A5A);
    issue(12'h008, 1'b1, 1'b1, 1'b0, 32'h0);
    chk("R3 dev", {32'b0, dq_out}, {32'b0, 32'h5A5A5A5A});
    // R2: full mask keeps every bit
    load_mask(3, 64'h00000000_FFFFFFFF);
    issue(12'h0C8, 1'b0, 1'b1, 1'b0, 32'h0);
    issue(12'h008, 1'b1, 1'b1, 1'b0, 32'h0);
    chk("R2 full mask", {32'b0, dq_out}, {32'b0, 32'h5A5A5A5A});

    // R12: mask load in the same cycle as a masked write uses the old mask
    mask_ld_en = 1'b1; mask_ld_sel = 3'd2; mask_ld_data = 64'h00000000_FFFFFFFF;
    issue(12'h084, 1'b0, 1'b1, 1'b0, 32'h0);
    issue(12'h004, 1'b1, 1'b1, 1'b0, 32'h0);
    chk("R12 old mask", {32'b0, dq_out}, 64'd0);
    issue(12'h084, 1'b0, 1'b1, 1'b0, 32'hFFFFFFFF);
    issue(12'h004, 1'b1, 1'b1, 1'b0, 32'h0);
    chk("R12 new mask", {32'b0, dq_out}, 64'd0);

    // R5: next lowest index after clearing slot 5
    set_vld(5, 1'b0);
    // R12: validity update in the same cycle as a next-free read
    vld_wr_en = 1'b1; vld_idx = 6'd2; vld_set = 1'b1;
    issue(12'h003, 1'b1, 1'b1, 1'b0, 32'h0);
    chk("R12 old scan", {32'b0, dq_out}, {32'b0, 32'h000A0009});
    issue(12'h003, 1'b1, 1'b1, 1'b0, 32'h0);
    chk("R5 new scan", {32'b0, dq_out}, {32'b0, 32'h000A0002});

    // R6: empty array
    set_vld(2, 1'b0);
    set_vld(9, 1'b0);
    chk("R6 full", {63'b0, full}, 64'd1);
    issue(12'h003, 1'b1, 1'b1, 1'b0, 32'h0);
    chk("R6 nfa oe", {63'b0, dq_oe}, 64'd1);
    chk("R6 nfa dq", {32'b0, dq_out}, 64'd0);
    issue(12'h007, 1'b1, 1'b1, 1'b0, 32'h0);
    chk("R9 status", {32'b0, dq_out}, {32'b0, 32'h00000003});

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule